// File: doc/BRIEF.md
# Configurable GPIO Pin Bank

This block controls a bank of general-purpose I/O pins. Each pin has its own 8-bit setup register. That register decides the pin's direction, whether its values are inverted, whether it drives as push-pull or as open-drain, whether it drives an alternate-function signal in place of its own data latch, and whether a rising input raises an interrupt request. For every pin the block produces a pad output-enable and a pad output value. It brings each pad input in through a two-flop synchroniser and raises a one-clock interrupt pulse per pin.

Software reaches the bank through one byte-wide register port. Setup registers can be changed only while the configuration-state flag `cfg_mode` is high. Writes made outside that state are dropped. The shared data register can be read and written at any time. Reads are combinational from the address. Writes take effect on the clock edge where `reg_wr` is high.

Top module: `gpio_bank`

## Requirements
- R1: After reset every setup register reads 0x01: input mode, non-inverting, push-pull, own data, interrupt off. All `pad_oe`, `pad_out` and `irq` bits are 0, and the data latches are 0.
- R2: Setup bit 0 selects direction, with 1 meaning input. An input pin keeps `pad_oe` low. A push-pull output pin holds `pad_oe` high and drives `pad_out` with its driven value.
- R3: Setup bit 1 inverts the pin's values. The driven value is the source bit XOR bit 1. The value seen by software for an input pin is the synchronised pad level XOR bit 1.
- R4: Setup bit 2 selects open-drain. An open-drain output raises `pad_oe` only when the driven value (after inversion) is 0, and `pad_out` is then 0. When `pad_oe` is high in open-drain mode, `pad_out` is never 1.
- R5: Setup bit 3 makes an output pin take its source bit from `alt_src[i]` in place of its data latch.
- R6: When setup bit 4 is set and the pin is an input, `irq[i]` goes high for exactly one clock on each 0-to-1 change of the inverted, synchronised input value. No pulse occurs on a 1-to-0 change or when bit 4 is clear.
- R7: A write to a setup register while `cfg_mode` is low leaves that register unchanged.
- R8: Setup bits 7:5 are reserved. They ignore writes and always read 0.
- R9: Address 8 is the data register, readable and writable whatever the value of `cfg_mode`. A write loads bit i into pin i's data latch. A read returns, in bit i, the input value (R3) for an input pin and the data latch for an output pin.
- R10: A pad input change made before clock edge k becomes visible in the data register read after edge k+1, and not before.
- R11: Addresses 0 to 7 select the setup register of pins 0 to 7. Every address other than 0 to 8 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 1 | Configuration-state flag; high allows setup writes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pad_in | input | NUM_PINS (8) | Pad input levels, asynchronous |
| alt_src | input | NUM_PINS (8) | Alternate-function output sources |
| pad_oe | output | NUM_PINS (8) | Pad output enables |
| pad_out | output | NUM_PINS (8) | Pad output values |
| irq | output | NUM_PINS (8) | Per-pin interrupt request pulses |

## Verification
A wrong setup register shows at the pads as soon as the write's clock edge has passed. The pin's `pad_oe`/`pad_out` pair stops matching the value computed from the setup bits, the data latch and `alt_src`, and a read-back of the register shows the same error in the same cycle. A fault in the synchroniser or the edge detector shows two or three edges after a pad change. It appears as a data-register bit that changes one cycle early or late, or as an `irq` pulse that is missing, doubled or on the wrong edge. Random setups, data, alternate sources and pad levels are checked against a bench-computed model, and directed cases cover lock-out, reserved bits, open-drain levels and interrupt edges.

// File: rtl/gpio_bank_pkg.sv
// Package: shared setup-register layout for the GPIO pin bank.
// Assumes: 8-bit setup registers; bits above the interrupt enable are reserved.
package gpio_bank_pkg;
    localparam int CFG_W   = 8;
    localparam int BIT_DIR = 0;   // 1 = input
    localparam int BIT_POL = 1;   // 1 = invert
    localparam int BIT_OD  = 2;   // 1 = open-drain
    localparam int BIT_ALT = 3;   // 1 = alternate source
    localparam int BIT_IEN = 4;   // 1 = interrupt enable
    localparam logic [CFG_W-1:0] CFG_RST  = 8'h01;
    localparam logic [CFG_W-1:0] CFG_MASK = 8'h1F;
endpackage

// File: rtl/gpio_pin.sv
// Module: gpio_pin
// One pin slice. It holds the pin's setup register and data latch, works out the
// pad drive, synchronises the pad input and detects rising input edges.
// Assumes: pad_in is asynchronous; the caller gates cfg_we with the config state.
module gpio_pin
    import gpio_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             dat_we,
    input  logic             dat_wbit,
    input  logic             pad_in,
    input  logic             alt_src,
    output logic [CFG_W-1:0] cfg_q,
    output logic             dat_rbit,
    output logic             pad_oe,
    output logic             pad_out,
    output logic             irq
);
    logic [CFG_W-1:0] cfg_r;
    logic             lat_r;
    logic             sync1_r, sync2_r;
    logic             prev_r;
    logic             in_val, drv_src, drv_val;
    logic             is_in, inv, od;

    assign is_in = cfg_r[BIT_DIR];
    assign inv   = cfg_r[BIT_POL];
    assign od    = cfg_r[BIT_OD];

    // Setup register: loads masked write data, so reserved bits stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_r <= CFG_RST;
        else if (cfg_we) cfg_r <= cfg_wdata & CFG_MASK;
    end

    // Data latch: the value an output pin drives in GPIO mode.
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_r <= 1'b0;
        else if (dat_we) lat_r <= dat_wbit;
    end

    // Two-flop synchroniser for the asynchronous pad level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_r <= 1'b0;
            sync2_r <= 1'b0;
        end else begin
            sync1_r <= pad_in;
            sync2_r <= sync1_r;
        end
    end

    // Input value after optional inversion.
    assign in_val = sync2_r ^ inv;

    // Previous input value, for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_r <= 1'b0;
        else        prev_r <= in_val;
    end

    // Drive path: pick the source, apply inversion, then form the pad signals.
    always_comb begin
        drv_src = cfg_r[BIT_ALT] ? alt_src : lat_r;
        drv_val = drv_src ^ inv;
        if (is_in) begin
            pad_oe  = 1'b0;
            pad_out = 1'b0;
        end else if (od) begin
            pad_oe  = ~drv_val;
            pad_out = 1'b0;
        end else begin
            pad_oe  = 1'b1;
            pad_out = drv_val;
        end
    end

    assign irq      = cfg_r[BIT_IEN] & is_in & in_val & ~prev_r;
    assign dat_rbit = is_in ? in_val : lat_r;
    assign cfg_q    = cfg_r;

    // R2: an input pin never enables its pad driver
    a_r2_input_floats: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[BIT_DIR] |-> !pad_oe);
    // R4: open-drain never drives a high level
    a_r4_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && cfg_q[BIT_OD]) |-> !pad_out);
    // R6: interrupt request lasts a single clock
    a_r6_irq_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R8: reserved setup bits stay clear
    a_r8_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[CFG_W-1:BIT_IEN+1] == '0);
endmodule

// File: rtl/gpio_regport.sv
// Module: gpio_regport
// Byte-wide register port decode. It steers writes to the setup registers (only in
// config state) or to the data register, and muxes read data.
// Assumes: NUM_PINS <= 8 and ADDR_W >= 4; the data register sits at 2**(ADDR_W-1).
module gpio_regport
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                      cfg_mode,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [NUM_PINS*CFG_W-1:0] cfg_flat,
    input  logic [NUM_PINS-1:0]       dat_flat,
    output logic [NUM_PINS-1:0]       cfg_we,
    output logic                      dat_we,
    output logic [7:0]                reg_rdata
);
    localparam logic [ADDR_W-1:0] DATA_IDX = ADDR_W'(1) << (ADDR_W - 1);

    // Per-pin setup write enables, locked outside config state.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_we
        assign cfg_we[i] = reg_wr & cfg_mode & (reg_addr == ADDR_W'(i));
    end

    assign dat_we = reg_wr & (reg_addr == DATA_IDX);

    // Read mux: data register, a setup register, or zero for unmapped addresses.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == DATA_IDX) begin
            reg_rdata[NUM_PINS-1:0] = dat_flat;
        end else begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (reg_addr == ADDR_W'(i)) reg_rdata = cfg_flat[i*CFG_W +: CFG_W];
            end
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// Module: gpio_bank (top)
// Bank of NUM_PINS configurable GPIO pins behind a byte-wide register port.
// Assumes: synchronous active-low reset; pad_in and alt_src may be asynchronous.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_mode,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] alt_src,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] irq
);
    logic [NUM_PINS*CFG_W-1:0] cfg_flat;
    logic [NUM_PINS-1:0]       dat_flat;
    logic [NUM_PINS-1:0]       cfg_we;
    logic                      dat_we;

    gpio_regport #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regport (
        .cfg_mode (cfg_mode),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .cfg_flat (cfg_flat),
        .dat_flat (dat_flat),
        .cfg_we   (cfg_we),
        .dat_we   (dat_we),
        .reg_rdata(reg_rdata)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        gpio_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[i]),
            .cfg_wdata(reg_wdata),
            .dat_we   (dat_we),
            .dat_wbit (reg_wdata[i]),
            .pad_in   (pad_in[i]),
            .alt_src  (alt_src[i]),
            .cfg_q    (cfg_flat[i*CFG_W +: CFG_W]),
            .dat_rbit (dat_flat[i]),
            .pad_oe   (pad_oe[i]),
            .pad_out  (pad_out[i]),
            .irq      (irq[i])
        );
    end

    // R7: setup registers hold while the config-state flag was low
    a_r7_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> $stable(cfg_flat));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [N-1:0] pad_in = '0, alt_src = '0, pad_oe, pad_out, irq;

    int total = 0, bad = 0;
    logic [7:0] cfg_sh [N];
    logic [7:0] lat_sh = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .alt_src(alt_src), .pad_oe(pad_oe),
        .pad_out(pad_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Expected {oe,out} for one pin from the requirements R2-R5.
    function automatic logic [1:0] exp_pad(input logic [7:0] c, input logic lat, input logic alt);
        logic v;
        v = (c[3] ? alt : lat) ^ c[1];
        if (c[0])      return 2'b00;
        else if (c[2]) return {~v, 1'b0};
        else           return {1'b1, v};
    endfunction

    // Expected data-register read (R9, R3).
    function automatic logic [7:0] exp_data(input logic [N-1:0] pin);
        logic [7:0] r = '0;
        for (int i = 0; i < N; i++)
            r[i] = cfg_sh[i][0] ? (pin[i] ^ cfg_sh[i][1]) : lat_sh[i];
        return r;
    endfunction

    function automatic int irq_count_unused(input int x);
        return x;
    endfunction

    task automatic count_irq(input int pin, output int cnt);
        cnt = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (irq[pin]) cnt++;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        int cnt;
        void'($urandom(32'h1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < N; i++) begin
            rd(4'(i), d); chk("R1 cfg reset", d, 8'h01);
            cfg_sh[i] = 8'h01;
        end
        chk("R1 pad_oe reset", pad_oe, 0);
        chk("R1 pad_out reset", pad_out, 0);
        chk("R1 irq reset", irq, 0);

        // R7: writes locked outside config state
        cfg_mode = 1'b0;
        wr(4'd0, 8'h00);
        rd(4'd0, d); chk("R7 locked write", d, 8'h01);
        chk("R7 pad_oe unchanged", pad_oe[0], 1'b0);

        // R8: reserved bits read zero
        cfg_mode = 1'b1;
        wr(4'd0, 8'hE0);
        rd(4'd0, d); chk("R8 reserved bits", d, 8'h00);
        cfg_sh[0] = 8'h00;

        // R2 / R9: push-pull output follows latch, data write outside config state
        cfg_mode = 1'b0;
        wr(4'd8, 8'h01); lat_sh = 8'h01;
        chk("R2 push-pull oe", pad_oe[0], 1'b1);
        chk("R2 push-pull out", pad_out[0], 1'b1);
        rd(4'd8, d); chk("R9 data read output latch", d[0], 1'b1);
        cfg_mode = 1'b1;

        // R3: output inversion
        wr(4'd0, 8'h02);
        chk("R3 inverted output", pad_out[0], 1'b0);

        // R4: open-drain levels
        wr(4'd0, 8'h04);
        chk("R4 od high releases", pad_oe[0], 1'b0);
        wr(4'd8, 8'h00); lat_sh = 8'h00;
        chk("R4 od low drives oe", pad_oe[0], 1'b1);
        chk("R4 od low drives 0", pad_out[0], 1'b0);

        // R5: alternate source
        wr(4'd0, 8'h08);
        @(negedge clk); alt_src[0] = 1'b1;
        #1 chk("R5 alt source high", pad_out[0], 1'b1);
        alt_src[0] = 1'b0;
        #1 chk("R5 alt source low", pad_out[0], 1'b0);

        // R10: two-flop latency on pin 1 (input by reset)
        @(negedge clk); pad_in[1] = 1'b1;
        @(negedge clk); rd(4'd8, d); chk("R10 not yet visible", d[1], 1'b0);
        @(negedge clk); rd(4'd8, d); chk("R10 visible after 2 edges", d[1], 1'b1);
        // R3: input inversion
        wr(4'd1, 8'h03);
        rd(4'd8, d); chk("R3 inverted input", d[1], 1'b0);

        // R6: interrupt edges on pin 2
        wr(4'd2, 8'h11);
        repeat (4) @(negedge clk);
        pad_in[2] = 1'b1; count_irq(2, cnt); chk("R6 rising pulse", cnt, 1);
        pad_in[2] = 1'b0; count_irq(2, cnt); chk("R6 falling no pulse", cnt, 0);
        wr(4'd2, 8'h01);
        pad_in[2] = 1'b1; count_irq(2, cnt); chk("R6 disabled no pulse", cnt, 0);
        wr(4'd2, 8'h13);
        repeat (3) @(negedge clk);
        pad_in[2] = 1'b0; count_irq(2, cnt); chk("R6 inverted rising pulse", cnt, 1);

        // R11: unmapped addresses
        wr(4'd9, 8'hFF);
        rd(4'd9, d); chk("R11 unmapped read", d, 8'h00);
        rd(4'd15, d); chk("R11 unmapped read high", d, 8'h00);

        // Reload shadows for the random phase.
        cfg_sh[1] = 8'h03; cfg_sh[2] = 8'h13; cfg_sh[0] = 8'h08;

        // Random phase: R2-R5, R7-R9
        for (int it = 0; it < 300; it++) begin
            int p;
            logic [7:0] c;
            logic lock;
            p = int'($urandom % N);
            c = 8'($urandom);
            lock = ($urandom % 4) == 0;
            cfg_mode = ~lock;
            wr(4'(p), c);
            if (!lock) cfg_sh[p] = c & 8'h1F;
            c = 8'($urandom);
            wr(4'd8, c); lat_sh = c;
            alt_src = N'($urandom);
            pad_in = N'($urandom);
            repeat (3) @(negedge clk);
            rd(4'(p), d); chk("R7 R8 random cfg readback", d, cfg_sh[p]);
            for (int i = 0; i < N; i++)
                chk("R2 R3 R4 R5 random pad", {pad_oe[i], pad_out[i]},
                    exp_pad(cfg_sh[i], lat_sh[i], alt_src[i]));
            rd(4'd8, d); chk("R9 random data read", d, exp_data(pad_in));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule